// File: doc/BRIEF.md
# Bit-Plane Dual-Half Pixel Serializer

This block turns one row of packed pixel words into the serial data and shift clock that a HUB75 LED panel expects, for a single binary-weighted bit plane. Pixel words arrive on a valid/ready stream. Each pixel occupies two 32-bit words, and each word holds two 16-bit lanes. Upper-half and lower-half pixels alternate in the stream, so four consecutive words make one panel column.

For each column, the block takes one bit from each colour lane of both pixels. The bit index is given by a plane selector. The block places the six bits on the panel data lines, then raises the panel shift clock for a fixed number of cycles. Input is held off while a column is being shifted.

A row is a fixed number of columns. When the clock pulse of the last column ends, a one-cycle done pulse is issued. The plane selector is captured with the first word of each row, so the surrounding row controller may change it between rows without disturbing a row already in progress.

Top module: `hub_plane_serializer`

## Requirements
- R1: Lane layout. In the first word of a pixel, bits [15:0] are ignored padding and bits [31:16] carry red. In the second word, bits [15:0] carry green and bits [31:16] carry blue.
- R2: Half pairing. In each group of four words, words 0 and 1 form the upper pixel and words 2 and 3 form the lower pixel. Output bit mapping: rgb_o[0]=red upper, [1]=green upper, [2]=blue upper, [3]=red lower, [4]=green lower, [5]=blue lower.
- R3: Plane selection. For plane n (0 to 15; 12-bit colour uses 0 to 11), each output bit is bit n of its 16-bit lane, which is word bit n for the low lane and word bit 16+n for the high lane.
- R4: The plane used for a whole row is the value of plane_i at the handshake of the row's first word. Changes to plane_i later in the row have no effect on that row's output.
- R5: rgb_o takes the new column value on the clock edge that accepts the column's fourth word. pclk_o stays low in the following cycle, then is high for exactly CLK_HI consecutive cycles.
- R6: rgb_o does not change while pclk_o is high.
- R7: word_ready_o is low from the acceptance of a column's fourth word until pclk_o falls for that column. pclk_o is never high while word_ready_o is high.
- R8: When pclk_o falls after the COLS-th column of a row, row_done_o is high for exactly that one cycle, with pclk_o low. The next word starts a new row.
- R9: In reset and right after it, word_ready_o=1, pclk_o=0, rgb_o=0 and row_done_o=0.
- R10: Exactly one pclk_o pulse is produced per column of four words. There are no extra lead or trail pulses, so a row gives COLS pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| plane_i | input | 4 | Bit plane selector, captured at the first word of a row |
| word_i | input | 32 | Pixel word, two 16-bit lanes |
| word_valid_i | input | 1 | word_i is valid |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| rgb_o | output | 6 | Panel data lines: upper R,G,B then lower R,G,B |
| pclk_o | output | 1 | Panel shift clock |
| row_done_o | output | 1 | One-cycle pulse at the end of a row |

## Verification
The bench changes plane_i right after a row's first word; a design that re-reads the selector mid-row would mix planes within that row. It fills the padding lane and the lanes' unselected bits with random data, including the extreme planes 0, 11 and 15; a lane or offset error would leak padding or neighbouring bits onto the data lines. Random stall gaps on the valid side, together with checks on the high-pulse length and the ready/clock overlap, catch a sequencer that accepts words during the pulse or shortens it. Counting pulses and done strobes per row exposes a pipeline that emits a garbage lead column or a dummy trail column.

// File: rtl/hub_ser_pkg.sv
// Package: shared types for the bit-plane serializer.
// Assumes: nothing beyond IEEE 1800-2017.
package hub_ser_pkg;

    // Phases of one column: gather words, settle data, hold shift clock high.
    typedef enum logic [1:0] {
        SQ_GATHER = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_HIGH   = 2'd2
    } sq_state_e;

    // Word position inside a column group.
    localparam int unsigned WORDS_PER_COL = 4;

endpackage

// File: rtl/lane_bit_pick.sv
// Module: lane_bit_pick
// Picks bit sel_i from both 16-bit lanes of a packed word.
// Assumes: sel_i width is exactly log2 of the lane width.
module lane_bit_pick #(
    parameter int LANE_W  = 16,
    parameter int PLANE_W = $clog2(LANE_W)
) (
    input  logic [2*LANE_W-1:0] word_i,
    input  logic [PLANE_W-1:0]  sel_i,
    output logic                lo_bit_o,
    output logic                hi_bit_o
);

    logic [LANE_W-1:0] lo_lane;
    logic [LANE_W-1:0] hi_lane;

    // Split the word into its two lanes.
    assign lo_lane = word_i[LANE_W-1:0];
    assign hi_lane = word_i[2*LANE_W-1:LANE_W];

    // Select the plane bit out of each lane.
    assign lo_bit_o = lo_lane[sel_i];
    assign hi_bit_o = hi_lane[sel_i];

endmodule

// File: rtl/column_gather.sv
// Module: column_gather
// Tracks the word position within a column and keeps the plane bits of
// the first three words, so that the full six-bit column is ready when the
// fourth word is present.
// Assumes: take_i is a completed handshake; words come in column order.
module column_gather #(
    parameter int LANE_W  = 16,
    parameter int PLANE_W = $clog2(LANE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic [2*LANE_W-1:0] word_i,
    input  logic [PLANE_W-1:0]  sel_i,
    output logic [1:0]          pos_o,
    output logic                last_o,
    output logic [5:0]          col_o
);

    logic       lo_bit;
    logic       hi_bit;
    logic [1:0] pos_q;
    logic       red_up_q;
    logic       grn_up_q;
    logic       blu_up_q;
    logic       red_dn_q;

    lane_bit_pick #(
        .LANE_W (LANE_W),
        .PLANE_W(PLANE_W)
    ) u_pick (
        .word_i  (word_i),
        .sel_i   (sel_i),
        .lo_bit_o(lo_bit),
        .hi_bit_o(hi_bit)
    );

    // Advance the word position and store the plane bits per word slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= 2'd0;
            red_up_q <= 1'b0;
            grn_up_q <= 1'b0;
            blu_up_q <= 1'b0;
            red_dn_q <= 1'b0;
        end else if (take_i) begin
            pos_q <= pos_q + 2'd1;
            case (pos_q)
                2'd0: red_up_q <= hi_bit;
                2'd1: begin
                    grn_up_q <= lo_bit;
                    blu_up_q <= hi_bit;
                end
                2'd2: red_dn_q <= hi_bit;
                default: ;
            endcase
        end
    end

    // Complete column: the fourth word supplies the lower green and blue.
    assign pos_o  = pos_q;
    assign last_o = (pos_q == 2'd3);
    assign col_o  = {hi_bit, lo_bit, red_dn_q, blu_up_q, grn_up_q, red_up_q};

endmodule

// File: rtl/pclk_sequencer.sv
// Module: pclk_sequencer
// Runs the per-column phases: gather (ready), one settle cycle, then
// CLK_HI cycles of shift clock high. Counts columns and pulses done at
// the end of the last column of a row.
// Assumes: col_in_i is asserted only in the gather phase.
module pclk_sequencer
    import hub_ser_pkg::*;
#(
    parameter int COLS   = 64,
    parameter int CLK_HI = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_in_i,
    output logic ready_o,
    output logic pclk_o,
    output logic row_first_o,
    output logic done_o
);

    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int HI_W  = (CLK_HI > 1) ? $clog2(CLK_HI) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [HI_W-1:0]  HI_LAST  = HI_W'(CLK_HI - 1);

    sq_state_e        st_q;
    logic [HI_W-1:0]  hi_cnt_q;
    logic [COL_W-1:0] col_cnt_q;
    logic             done_q;

    // Column phase machine with pulse-length and column counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SQ_GATHER;
            hi_cnt_q  <= '0;
            col_cnt_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SQ_GATHER: if (col_in_i) st_q <= SQ_SETTLE;
                SQ_SETTLE: begin
                    st_q     <= SQ_HIGH;
                    hi_cnt_q <= '0;
                end
                SQ_HIGH: begin
                    if (hi_cnt_q == HI_LAST) begin
                        st_q <= SQ_GATHER;
                        if (col_cnt_q == COL_LAST) begin
                            col_cnt_q <= '0;
                            done_q    <= 1'b1;
                        end else begin
                            col_cnt_q <= col_cnt_q + 1'b1;
                        end
                    end else begin
                        hi_cnt_q <= hi_cnt_q + 1'b1;
                    end
                end
                default: st_q <= SQ_GATHER;
            endcase
        end
    end

    // Phase decodes driven to the ports.
    assign ready_o     = (st_q == SQ_GATHER);
    assign pclk_o      = (st_q == SQ_HIGH);
    assign row_first_o = (col_cnt_q == '0);
    assign done_o      = done_q;

endmodule

// File: rtl/hub_plane_serializer.sv
// Module: hub_plane_serializer (top)
// Streams one panel row for one bit plane: four words per column, six
// data bits per column, one shift-clock pulse per column.
// Assumes: the plane selector is meant per row; COLS >= 1, CLK_HI >= 1.
module hub_plane_serializer #(
    parameter int COLS   = 64,
    parameter int CLK_HI = 8,
    parameter int LANE_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(LANE_W)-1:0]   plane_i,
    input  logic [2*LANE_W-1:0]         word_i,
    input  logic                        word_valid_i,
    output logic                        word_ready_o,
    output logic [5:0]                  rgb_o,
    output logic                        pclk_o,
    output logic                        row_done_o
);

    localparam int PLANE_W = $clog2(LANE_W);

    logic               take;
    logic               ready;
    logic               row_first;
    logic [1:0]         pos;
    logic               last;
    logic [5:0]         col_bits;
    logic [PLANE_W-1:0] plane_q;
    logic [PLANE_W-1:0] plane_eff;
    logic [5:0]         rgb_q;
    logic               row_head;

    assign take     = word_valid_i && ready;
    assign row_head = row_first && (pos == 2'd0);

    // The first word of a row uses the live selector; later words the held one.
    assign plane_eff = row_head ? plane_i : plane_q;

    column_gather #(
        .LANE_W (LANE_W),
        .PLANE_W(PLANE_W)
    ) u_gather (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(take),
        .word_i(word_i),
        .sel_i (plane_eff),
        .pos_o (pos),
        .last_o(last),
        .col_o (col_bits)
    );

    pclk_sequencer #(
        .COLS  (COLS),
        .CLK_HI(CLK_HI)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_in_i   (take && last),
        .ready_o    (ready),
        .pclk_o     (pclk_o),
        .row_first_o(row_first),
        .done_o     (row_done_o)
    );

    // Hold the plane for the row and load the data lines per column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_q <= '0;
            rgb_q   <= '0;
        end else begin
            if (take && row_head) plane_q <= plane_i;
            if (take && last)     rgb_q   <= col_bits;
        end
    end

    assign word_ready_o = ready;
    assign rgb_o        = rgb_q;

endmodule

// File: rtl/hub_plane_serializer_chk.sv
// Module: hub_plane_serializer_chk
// Temporal checks on the serializer ports, bound into the top module.
// Assumes: synchronous active-low reset.
module hub_plane_serializer_chk #(
    parameter int CLK_HI = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       word_valid_i,
    input logic       word_ready_o,
    input logic [5:0] rgb_o,
    input logic       pclk_o,
    input logic       row_done_o
);

    logic [31:0] hi_run;

    // Count how many cycles the shift clock has already been high.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_run <= '0;
        else if (pclk_o) hi_run <= hi_run + 32'd1;
        else             hi_run <= '0;
    end

    a_r7_no_clock_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> !pclk_o);

    a_r6_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_o |-> $stable(rgb_o));

    a_r5_data_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rgb_o) |-> ($past(word_valid_i && word_ready_o) && !pclk_o));

    a_r5_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_o |-> (hi_run < CLK_HI));

    a_r5_high_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pclk_o) |-> (hi_run == CLK_HI));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        row_done_o |=> !row_done_o);

    a_r8_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        row_done_o |-> ($past(pclk_o) && !pclk_o));

    a_r10_rise_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pclk_o) |-> $past(!word_ready_o));

endmodule

bind hub_plane_serializer hub_plane_serializer_chk #(
    .CLK_HI(CLK_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o),
    .rgb_o       (rgb_o),
    .pclk_o      (pclk_o),
    .row_done_o  (row_done_o)
);

// File: tb/hub_plane_serializer_tb.sv
module hub_plane_serializer_tb;

    localparam int CLK_P  = 10;
    localparam int COLS   = 6;
    localparam int CLK_HI = 8;
    localparam int NWORDS = COLS * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  plane_i = '0;
    logic [31:0] word_i = '0;
    logic        word_valid_i = 1'b0;
    logic        word_ready_o;
    logic [5:0]  rgb_o;
    logic        pclk_o;
    logic        row_done_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] row_words [NWORDS];
    logic [5:0]  exp_col   [COLS];
    logic [5:0]  exp_q [$];

    bit monitor_on = 1'b0;
    int pulses_in_row = 0;
    int rows_done = 0;
    int high_len = 0;
    int overlap_errs = 0;
    logic prev_pclk = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hub_plane_serializer #(
        .COLS  (COLS),
        .CLK_HI(CLK_HI),
        .LANE_W(16)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .plane_i     (plane_i),
        .word_i      (word_i),
        .word_valid_i(word_valid_i),
        .word_ready_o(word_ready_o),
        .rgb_o       (rgb_o),
        .pclk_o      (pclk_o),
        .row_done_o  (row_done_o)
    );

    function automatic logic [5:0] col_expect(input logic [31:0] w0, input logic [31:0] w1,
                                              input logic [31:0] w2, input logic [31:0] w3,
                                              input int n);
        return {w3[16+n], w3[n], w2[16+n], w1[16+n], w1[n], w0[16+n]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic print_summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Monitor at the falling edge: pulse data, pulse length, done timing.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (pclk_o && word_ready_o) overlap_errs++;
            if (pclk_o && !prev_pclk) begin
                // R2 R3 R10: every pulse carries the next expected column
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 extra pulse", 1, 0);
                end else begin
                    check(rgb_o == exp_q[0], "R2 column bits at pulse", rgb_o, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                pulses_in_row++;
                high_len = 1;
            end else if (pclk_o) begin
                high_len++;
            end else if (prev_pclk) begin
                check(high_len == CLK_HI, "R5 high length", high_len, CLK_HI);
            end
            if (row_done_o) begin
                check(!pclk_o && prev_pclk, "R8 done at clock fall", pclk_o, 0);
                check(pulses_in_row == COLS, "R10 pulses per row", pulses_in_row, COLS);
                pulses_in_row = 0;
                rows_done++;
            end
            prev_pclk = pclk_o;
        end
    end

    // Offer one word after a number of idle cycles; returns at the negedge after the handshake.
    task automatic send_word(input logic [31:0] w, input int gap);
        for (int g = 0; g < gap; g++) begin
            word_valid_i = 1'b0;
            @(negedge clk);
        end
        word_valid_i = 1'b1;
        word_i = w;
        while (!word_ready_o) @(negedge clk);
        @(negedge clk);
        word_valid_i = 1'b0;
        word_i = $urandom();
    endtask

    // Send row_words for plane pl; optionally disturb plane_i after the first word.
    task automatic run_row(input logic [3:0] pl, input bit wiggle, input int maxgap);
        int target;
        target = rows_done + 1;
        for (int c = 0; c < COLS; c++) begin
            exp_col[c] = col_expect(row_words[4*c], row_words[4*c+1],
                                    row_words[4*c+2], row_words[4*c+3], int'(pl));
            exp_q.push_back(exp_col[c]);
        end
        plane_i = pl;
        for (int i = 0; i < NWORDS; i++) begin
            send_word(row_words[i], (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0);
            if (i == 0 && wiggle) plane_i = pl ^ 4'hF; // R4: later changes must be ignored
            if (i % 4 == 3) begin
                // R5 R7: new data present, clock still low, input held off
                check(rgb_o == exp_col[i/4], "R5 data after fourth word", rgb_o, exp_col[i/4]);
                check(!pclk_o && !word_ready_o, "R7 settle cycle", {pclk_o, word_ready_o}, 0);
            end
        end
        while (rows_done < target) @(negedge clk);
        check(exp_q.size() == 0, "R4 row fully emitted", exp_q.size(), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        print_summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(word_ready_o && !pclk_o && rgb_o == 6'd0 && !row_done_o, "R9 in reset",
              {word_ready_o, pclk_o, rgb_o, row_done_o}, 9'h100);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_ready_o && !pclk_o && rgb_o == 6'd0 && !row_done_o, "R9 after reset",
              {word_ready_o, pclk_o, rgb_o, row_done_o}, 9'h100);
        monitor_on = 1'b1;

        // R1: only padding lane set, plane 0 -> upper red must read zero
        for (int i = 0; i < NWORDS; i++) row_words[i] = (i % 2 == 0) ? 32'h0000_FFFF : 32'h0;
        run_row(4'd0, 1'b0, 0);
        check(rgb_o == 6'd0, "R1 padding ignored", rgb_o, 0);

        // R2: only upper pixel words set, plane 11
        for (int i = 0; i < NWORDS; i++) row_words[i] = (i % 4 < 2) ? 32'hFFFF_FFFF : 32'h0;
        run_row(4'd11, 1'b0, 1);
        check(rgb_o == 6'b000111, "R2 upper lines only", rgb_o, 6'b000111);

        // R3: one bit per lane at the top plane 15
        for (int i = 0; i < NWORDS; i++) row_words[i] = 32'h8000_8000;
        run_row(4'd15, 1'b0, 0);
        check(rgb_o == 6'b111111, "R3 plane 15", rgb_o, 6'b111111);

        // R4: plane changed after the first word of the row
        for (int i = 0; i < NWORDS; i++) row_words[i] = $urandom();
        run_row(4'd3, 1'b1, 2);

        // Random rows: random planes 0..11 and random stalls
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < NWORDS; i++) row_words[i] = $urandom();
            run_row(4'($urandom_range(0, 11)), r[0], 3);
        end

        repeat (4) @(negedge clk);
        // R7: clock never high while ready over the whole run
        check(overlap_errs == 0, "R7 ready and clock overlap", overlap_errs, 0);
        check(!pclk_o && word_ready_o, "R8 idle after rows", {pclk_o, word_ready_o}, 1);
        print_summary();
        $finish;
    end

endmodule